// File: doc/BRIEF.md
# Memory-Mapped Accumulator ALU

This block gives a processor that can only move words between addresses a way to do arithmetic and to branch. It holds one 16-bit accumulator and four condition flags: negative (N), zero (Z), signed overflow (O) and carry (C). It answers to a window of eight consecutive bus addresses.

A write into the window selects an operation by its low three address bits. The operation combines the written word with the accumulator and stores the result back in the accumulator. A read from the window returns either the accumulator or a condition word. A condition word is 2 when the condition holds and 0 when it does not, so a program can add it straight to its program counter to skip an instruction.

The bus is synchronous. Writes take effect at the clock edge. Read data is a combinational function of the current registers. A select output reports whether the present address lies inside the window.

Top module: `mmio_acc_alu`

## Requirements
- R1: After reset the accumulator and all four flags are zero. Reads then return 0 from offset 0, 0 from offsets 1 to 6, and 2 from offset 7.
- R2: `win_sel` is 1 exactly when `bus_addr` lies in BASE_ADDR..BASE_ADDR+7. With the default base 0xFFF0, the window is 0xFFF0..0xFFF7.
- R3: A write at a window offset (address minus base) performs the operation of that offset:
  - 0: load, acc=data
  - 1: acc=acc−data
  - 2: acc=data−acc
  - 3: acc=acc+data
  - 4: acc=acc XOR data
  - 5: acc=acc AND data
  - 6: acc=acc OR data
  - 7: acc=data logically shifted right by one
- R4: Add and subtract are one 16-bit add with carry-in. Addition adds acc and data with carry-in 0. Subtraction adds the minuend, the inverted subtrahend and carry-in 1. The flags after an add or subtract are:
  - C is the carry out of bit 15, so C=1 on a subtract that does not borrow.
  - O is the carry into bit 15 XOR the carry out of bit 15.
  - Z is 1 when the 16-bit result is zero.
  - N is bit 15 of the result.
- R5: XOR, AND, OR and shift set Z and N from their result, clear O and leave C unchanged. The shift fills bit 15 with zero.
- R6: A load at offset 0 leaves all four flags unchanged.
- R7: A read at offset 0 returns the accumulator. Reads at offsets 1 to 7 return 2 if the condition is true and 0 if it is false. The conditions are:
  - 1: N
  - 2: Z
  - 3: O
  - 4: C
  - 5: N^O
  - 6: (N^O)|Z
  - 7: C^~Z
- R8: A write outside the window, or a cycle with `bus_wr` low, changes neither the accumulator nor any flag.
- R9: `bus_rdata` is 0 whenever `bus_rd` is low or the address is outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, combinational |
| win_sel | output | 1 | Address lies in the window |

## Verification
The hardest state to reach is a carry left behind by an arithmetic write that must survive later logic writes, shifts and loads. Only the C read and the C^~Z read reveal it, and only while Z has a chosen value. The stimulus first forces a carry by adding 0x8000 to 0x8000, which also sets O and Z. It then applies AND, shift and load writes, and after each one reads every offset. Signed overflow in both directions, subtraction with and without borrow, and a long random run that mixes in writes outside the window and idle cycles cover the rest.

// File: rtl/mmio_acc_alu_pkg.sv
package mmio_acc_alu_pkg;

    localparam int OFS_W = 3;

    typedef enum logic [OFS_W-1:0] {
        OP_LOAD = 3'd0,
        OP_SUB  = 3'd1,
        OP_RSUB = 3'd2,
        OP_ADD  = 3'd3,
        OP_XOR  = 3'd4,
        OP_AND  = 3'd5,
        OP_OR   = 3'd6,
        OP_SHR  = 3'd7
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic o;
        logic c;
    } flags_t;

endpackage

// File: rtl/maa_decode.sv
module maa_decode
    import mmio_acc_alu_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [15:0] BASE_ADDR = 16'hFFF0
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output op_e           op
);
    localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);

    always_comb begin
        hit = (addr[AW-1:OFS_W] == BASE[AW-1:OFS_W]);
        op  = op_e'(addr[OFS_W-1:0]);
    end
endmodule

// File: rtl/maa_adder.sv
module maa_adder #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);
    logic [DW:0]   full;
    logic [DW-1:0] low;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        low  = {1'b0, a[DW-2:0]} + {1'b0, b[DW-2:0]} + {{(DW-1){1'b0}}, cin};
        sum  = full[DW-1:0];
        cout = full[DW];
        ovf  = low[DW-1] ^ full[DW];
    end
endmodule

// File: rtl/maa_exec.sv
module maa_exec
    import mmio_acc_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] data,
    input  flags_t        flags_q,
    output logic [DW-1:0] acc_nx,
    output flags_t        flags_nx
);
    logic [DW-1:0] opa, opb, sum, logic_res;
    logic          cin, cout, ovf;

    always_comb begin
        unique case (op)
            OP_SUB:  begin opa = acc;  opb = ~data; cin = 1'b1; end
            OP_RSUB: begin opa = data; opb = ~acc;  cin = 1'b1; end
            default: begin opa = acc;  opb = data;  cin = 1'b0; end
        endcase
    end

    maa_adder #(.DW(DW)) u_add (
        .a(opa), .b(opb), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
    );

    always_comb begin
        unique case (op)
            OP_XOR:  logic_res = acc ^ data;
            OP_AND:  logic_res = acc & data;
            OP_OR:   logic_res = acc | data;
            default: logic_res = {1'b0, data[DW-1:1]};
        endcase
    end

    always_comb begin
        unique case (op)
            OP_LOAD: begin
                acc_nx   = data;
                flags_nx = flags_q;
            end
            OP_SUB, OP_RSUB, OP_ADD: begin
                acc_nx     = sum;
                flags_nx.n = sum[DW-1];
                flags_nx.z = (sum == '0);
                flags_nx.o = ovf;
                flags_nx.c = cout;
            end
            default: begin
                acc_nx     = logic_res;
                flags_nx.n = logic_res[DW-1];
                flags_nx.z = (logic_res == '0);
                flags_nx.o = 1'b0;
                flags_nx.c = flags_q.c;
            end
        endcase
    end
endmodule

// File: rtl/maa_cond.sv
module maa_cond
    import mmio_acc_alu_pkg::*;
#(
    parameter int DW       = 16,
    parameter int TRUE_VAL = 2
) (
    input  op_e           sel,
    input  logic [DW-1:0] acc,
    input  flags_t        flags,
    output logic [DW-1:0] value
);
    localparam logic [DW-1:0] T_WORD = DW'(TRUE_VAL);
    logic bit_true;

    always_comb begin
        unique case (sel)
            OP_SUB:  bit_true = flags.n;
            OP_RSUB: bit_true = flags.z;
            OP_ADD:  bit_true = flags.o;
            OP_XOR:  bit_true = flags.c;
            OP_AND:  bit_true = flags.n ^ flags.o;
            OP_OR:   bit_true = (flags.n ^ flags.o) | flags.z;
            OP_SHR:  bit_true = flags.c ^ ~flags.z;
            default: bit_true = 1'b0;
        endcase
        value = (sel == OP_LOAD) ? acc : (bit_true ? T_WORD : '0);
    end
endmodule

// File: rtl/mmio_acc_alu.sv
module mmio_acc_alu
    import mmio_acc_alu_pkg::*;
#(
    parameter int          DW        = 16,
    parameter int          AW        = 16,
    parameter logic [15:0] BASE_ADDR = 16'hFFF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          win_sel
);
    logic          hit;
    op_e           op;
    logic [DW-1:0] acc_q, acc_nx, cond_val;
    flags_t        flags_q, flags_nx;

    maa_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr), .hit(hit), .op(op)
    );

    maa_exec #(.DW(DW)) u_exec (
        .op(op), .acc(acc_q), .data(bus_wdata), .flags_q(flags_q),
        .acc_nx(acc_nx), .flags_nx(flags_nx)
    );

    maa_cond #(.DW(DW), .TRUE_VAL(2)) u_cond (
        .sel(op), .acc(acc_q), .flags(flags_q), .value(cond_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (hit && bus_wr) begin
            acc_q   <= acc_nx;
            flags_q <= flags_nx;
        end
    end

    always_comb begin
        win_sel   = hit;
        bus_rdata = (hit && bus_rd) ? cond_val : '0;
    end

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && bus_wr) |=> ($stable(acc_q) && $stable(flags_q)));

    a_r6_load_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && op == OP_LOAD) |=> $stable(flags_q));

    a_r5_logic_clears_o: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && (op == OP_XOR || op == OP_AND || op == OP_OR || op == OP_SHR))
        |=> (!flags_q.o && flags_q.c == $past(flags_q.c)));

    a_r5_shift_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && op == OP_SHR) |=> (!acc_q[DW-1] && !flags_q.n));

    a_r7_cond_two_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_rd && op != OP_LOAD) |-> (bus_rdata == DW'(0) || bus_rdata == DW'(2)));

    a_r9_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && bus_rd) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_mmio_acc_alu.sv
module sim_mmio_acc_alu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        win_sel;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    logic [15:0] m_acc;
    bit m_n, m_z, m_o, m_c;

    mmio_acc_alu u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .win_sel(win_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            failures++;
            $display("FAIL watchdog expired got=%0d exp<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s got=0x%0h exp=0x%0h", req, what, got, exp);
        end
    endtask

    task automatic m_arith(logic [15:0] a, logic [15:0] b, bit cin);
        int s;
        logic [15:0] r;
        s = int'(a) + int'(b) + int'(cin);
        r = s[15:0];
        m_c = s[16];
        m_o = (a[15] == b[15]) && (r[15] != a[15]);
        m_acc = r;
        m_n = r[15];
        m_z = (r == 16'h0);
    endtask

    task automatic m_logic(logic [15:0] r);
        m_acc = r;
        m_n = r[15];
        m_z = (r == 16'h0);
        m_o = 0;
    endtask

    task automatic model_write(logic [15:0] addr, logic [15:0] d);
        if (addr >= 16'hFFF0 && addr <= 16'hFFF7) begin
            case (addr[2:0])
                3'd0: m_acc = d;
                3'd1: m_arith(m_acc, ~d, 1'b1);
                3'd2: m_arith(d, ~m_acc, 1'b1);
                3'd3: m_arith(m_acc, d, 1'b0);
                3'd4: m_logic(m_acc ^ d);
                3'd5: m_logic(m_acc & d);
                3'd6: m_logic(m_acc | d);
                default: m_logic(d / 2);
            endcase
        end
    endtask

    function automatic int exp_read(int ofs);
        bit t;
        case (ofs)
            0: return int'(m_acc);
            1: t = m_n;
            2: t = m_z;
            3: t = m_o;
            4: t = m_c;
            5: t = m_n != m_o;
            6: t = (m_n != m_o) || m_z;
            default: t = m_c == m_z;
        endcase
        return t ? 2 : 0;
    endfunction

    task automatic read_all(string tag);
        for (int k = 0; k < 8; k++) begin
            bus_addr = 16'hFFF0 + 16'(k);
            bus_rd = 1'b1;
            #1;
            check(k == 0 ? "R3" : "R7", $sformatf("%s read ofs %0d", tag, k),
                  int'(bus_rdata), exp_read(k));
            check("R2", $sformatf("%s sel ofs %0d", tag, k), int'(win_sel), 1);
        end
        bus_rd = 1'b0;
        #1;
        check("R9", {tag, " rd low"}, int'(bus_rdata), 0);
    endtask

    task automatic do_write(logic [15:0] addr, logic [15:0] d, bit wr);
        @(negedge clk);
        bus_addr = addr;
        bus_wdata = d;
        bus_wr = wr;
        bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
        if (wr) model_write(addr, d);
        #1;
    endtask

    initial begin
        m_acc = 0; m_n = 0; m_z = 0; m_o = 0; m_c = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset values, C^~Z reads 2
        read_all("R1 reset");
        check("R1", "reset ofs7", exp_read(7), 2);

        // R2, R9: boundaries of the window
        bus_addr = 16'hFFEF; bus_rd = 1'b1; #1;
        check("R2", "sel below", int'(win_sel), 0);
        check("R9", "rdata below", int'(bus_rdata), 0);
        bus_addr = 16'hFFF8; #1;
        check("R2", "sel above", int'(win_sel), 0);
        check("R9", "rdata above", int'(bus_rdata), 0);
        bus_rd = 1'b0;

        // R4: positive overflow
        do_write(16'hFFF0, 16'h7FFF, 1);
        do_write(16'hFFF3, 16'h0001, 1);
        read_all("R4 pos ovf");
        // R4: subtract equal -> Z, no borrow C=1
        do_write(16'hFFF0, 16'h0005, 1);
        do_write(16'hFFF1, 16'h0005, 1);
        read_all("R4 sub zero");
        // R4: borrow C=0
        do_write(16'hFFF0, 16'h0005, 1);
        do_write(16'hFFF1, 16'h0003, 1);
        read_all("R4 sub borrow");
        // R3: reverse subtract
        do_write(16'hFFF2, 16'h0002, 1);
        read_all("R3 rsub");
        // R4: negative overflow with carry and zero
        do_write(16'hFFF0, 16'h8000, 1);
        do_write(16'hFFF3, 16'h8000, 1);
        read_all("R4 neg ovf");
        check("R4", "carry model", int'(m_c), 1);
        // R5: logic keeps C, clears O
        do_write(16'hFFF0, 16'hF0F0, 1);
        read_all("R6 load keeps flags");
        do_write(16'hFFF5, 16'h0FF0, 1);
        read_all("R5 and");
        do_write(16'hFFF4, 16'hFFFF, 1);
        read_all("R5 xor");
        do_write(16'hFFF6, 16'h0001, 1);
        read_all("R5 or");
        do_write(16'hFFF7, 16'hFFFF, 1);
        read_all("R5 shift");
        check("R5", "shift result", exp_read(0), 16'h7FFF);
        // R8: writes outside window / strobe low
        do_write(16'hFFEF, 16'h1234, 1);
        read_all("R8 below");
        do_write(16'hFFF8, 16'h1234, 1);
        read_all("R8 above");
        do_write(16'hFFF0, 16'h1234, 0);
        read_all("R8 no strobe");

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a, d;
            int r;
            r = $urandom_range(0, 9);
            a = (r < 8) ? 16'hFFF0 + 16'(r) : 16'($urandom);
            d = 16'($urandom);
            if ($urandom_range(0, 3) == 0) d = 16'h8000 >> $urandom_range(0, 15);
            do_write(a, d, $urandom_range(0, 7) != 0);
            read_all("R3 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule